// File: doc/BRIEF.md
# 10 Mb/s Manchester Line Transmitter with Link Pulses

This block turns the transmit nibble stream from a MAC into the single serial Manchester-coded bit that feeds a 10 Mb/s twisted-pair driver. It runs on a 20 MHz clock. The 2.5 MHz nibble clock comes from the same source and arrives as a one-cycle strobe (`nib_en`) every eighth cycle. On each strobe the block captures a 4-bit nibble and the frame-enable flag. It sends the four bits least-significant first. Each bit takes two 20 MHz half-cells.

When a frame ends, the line is held high for a short idle marker and then goes quiet with the driver disabled. While no frame is being sent, the block emits a short high link pulse each time a programmable interval elapses. That interval restarts whenever the quiet period begins. Link pulses never appear inside a frame.

Top module: `mtx10_line`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `line_bit` and `drv_en` are both 0. The pulse interval timer starts from zero at release.
- R2: A nibble and the frame flag are captured only in a cycle where `nib_en` is 1. A change on `txd` between strobes has no effect on the bits being sent.
- R3: The captured nibble is sent least-significant bit first. Each bit occupies two consecutive clock cycles, starting in the cycle after the capturing edge.
- R4: Each bit is Manchester coded. The first half-cell carries the inverted bit and the second carries the bit itself, so a 1 is a low-to-high transition at mid-bit and a 0 is high-to-low.
- R5: `drv_en` is 1 in every cycle of a frame.
- R6: A strobe with `tx_en` low during a frame ends it. For TAIL_CYC cycles (default 5, 250 ns) `line_bit` and `drv_en` are both 1. After that both are 0.
- R7: After LP_GAP quiet cycles (default 320000, 16 ms), the block drives `line_bit` and `drv_en` to 1 for PULSE_CYC cycles (default 2, 100 ns). It then returns to quiet and starts the next interval. While quiet, `line_bit` is 0 whenever `drv_en` is 0.
- R8: No link pulse is emitted during a frame, however long it runs. The interval timer restarts when the idle marker ends.
- R9: A strobe with `tx_en` low outside a frame is ignored: both outputs stay 0 and no idle marker is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz half-cell clock |
| rst | input | 1 | Synchronous active-high reset |
| nib_en | input | 1 | One-cycle nibble strobe, every eighth clock |
| tx_en | input | 1 | Frame-enable flag from the MAC, sampled with `nib_en` |
| txd | input | 4 | Transmit nibble, sampled with `nib_en` |
| line_bit | output | 1 | Manchester-coded serial line value |
| drv_en | output | 1 | Line driver enable |

## Verification
The data path is driven with several nibble patterns:
- `0x5` repeats and alternates every bit, which exposes an inverted half-cell order.
- `0x0` and `0xF` hold one level, so any transition that appears comes from the coding itself.
- Asymmetric nibbles such as `0xD`, `0x8` and `0x1` show whether the bits go out LSB first or MSB first.

Between strobes the bench flips `txd`, which separates a proper capture from a pass-through. The frame is long enough to cover several pulse intervals, so a pulse that leaks into the data would show up.

After each frame the bench times the idle marker, the quiet gap and the following pulse cycle by cycle. It also checks a stray end strobe outside a frame and a reset in mid-frame.

// File: rtl/mtx10_pkg.sv
package mtx10_pkg;

    localparam int NIB_W       = 4;
    localparam int CELLS       = 2 * NIB_W;
    localparam int POS_W       = $clog2(CELLS);

    typedef enum logic [1:0] {
        LN_QUIET = 2'd0,
        LN_PULSE = 2'd1,
        LN_DATA  = 2'd2,
        LN_TAIL  = 2'd3
    } line_st_e;

    typedef struct packed {
        logic [POS_W-2:0] idx;
        logic             late;
    } cell_pos_t;

    function automatic logic manch_cell(input logic b, input logic late);
        return late ? b : ~b;
    endfunction

endpackage

// File: rtl/mtx10_nib_ser.sv
module mtx10_nib_ser
    import mtx10_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NIB_W-1:0] din,
    output logic             cell_bit,
    output logic             cell_late
);

    logic [NIB_W-1:0] nib_q;
    cell_pos_t        pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nib_q <= '0;
            pos_q <= '0;
        end else if (load) begin
            nib_q <= din;
            pos_q <= '0;
        end else begin
            pos_q <= cell_pos_t'(pos_q + 1'b1);
        end
    end

    assign cell_bit  = manch_cell(nib_q[pos_q.idx], pos_q.late);
    assign cell_late = pos_q.late;

    // R2
    hold_nib_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(nib_q));

endmodule

// File: rtl/mtx10_line_seq.sv
module mtx10_line_seq
    import mtx10_pkg::*;
#(
    parameter int LP_GAP    = 320000,
    parameter int PULSE_CYC = 2,
    parameter int TAIL_CYC  = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     nib_en,
    input  logic     tx_en,
    output line_st_e st
);

    localparam int TMR_W = $clog2(LP_GAP + 1) + 1;
    localparam logic [TMR_W-1:0] GAP_END   = TMR_W'(LP_GAP - 1);
    localparam logic [TMR_W-1:0] PULSE_END = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0] TAIL_END  = TMR_W'(TAIL_CYC - 1);

    line_st_e         st_q;
    logic [TMR_W-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LN_QUIET;
            tmr_q <= '0;
        end else if (nib_en && tx_en) begin
            st_q  <= LN_DATA;
            tmr_q <= '0;
        end else begin
            case (st_q)
                LN_DATA: begin
                    if (nib_en) begin
                        st_q  <= LN_TAIL;
                        tmr_q <= '0;
                    end
                end
                LN_TAIL: begin
                    if (tmr_q == TAIL_END) begin
                        st_q  <= LN_QUIET;
                        tmr_q <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                LN_PULSE: begin
                    if (tmr_q == PULSE_END) begin
                        st_q  <= LN_QUIET;
                        tmr_q <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: begin
                    if (tmr_q == GAP_END) begin
                        st_q  <= LN_PULSE;
                        tmr_q <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign st = st_q;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (st_q == LN_QUIET) && (tmr_q == '0));

    // R8
    frame_timer_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == LN_DATA) |-> (tmr_q == '0));

    // R6
    tail_after_data_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == LN_TAIL && $past(st_q) != LN_TAIL) |-> ($past(st_q) == LN_DATA));

endmodule

// File: rtl/mtx10_line.sv
module mtx10_line
    import mtx10_pkg::*;
#(
    parameter int LP_GAP    = 320000,
    parameter int PULSE_CYC = 2,
    parameter int TAIL_CYC  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nib_en,
    input  logic             tx_en,
    input  logic [NIB_W-1:0] txd,
    output logic             line_bit,
    output logic             drv_en
);

    line_st_e st;
    logic     ser_bit;
    logic     ser_late;

    mtx10_nib_ser u_ser (
        .clk       (clk),
        .rst       (rst),
        .load      (nib_en & tx_en),
        .din       (txd),
        .cell_bit  (ser_bit),
        .cell_late (ser_late)
    );

    mtx10_line_seq #(
        .LP_GAP    (LP_GAP),
        .PULSE_CYC (PULSE_CYC),
        .TAIL_CYC  (TAIL_CYC)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .nib_en (nib_en),
        .tx_en  (tx_en),
        .st     (st)
    );

    always_comb begin
        case (st)
            LN_DATA:  line_bit = ser_bit;
            LN_PULSE: line_bit = 1'b1;
            LN_TAIL:  line_bit = 1'b1;
            default:  line_bit = 1'b0;
        endcase
    end

    assign drv_en = (st != LN_QUIET);

    // R4
    mid_bit_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (st == LN_DATA && ser_late) |-> (line_bit != $past(line_bit)));

    // R7
    quiet_low_chk: assert property (@(posedge clk) disable iff (rst)
        !drv_en |-> !line_bit);

endmodule

// File: tb/sim_mtx10_line.sv
module sim_mtx10_line;

    localparam int GAP   = 40;
    localparam int PULSE = 2;
    localparam int TAIL  = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       nib_en = 1'b0;
    logic       tx_en = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       line_bit;
    logic       drv_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mtx10_line #(.LP_GAP(GAP), .PULSE_CYC(PULSE), .TAIL_CYC(TAIL)) u0 (
        .clk(clk), .rst(rst), .nib_en(nib_en), .tx_en(tx_en), .txd(txd),
        .line_bit(line_bit), .drv_en(drv_en)
    );

    // {tx_en, txd}: tx_en=0 marks end of frame
    localparam logic [4:0] VEC [0:13] = '{
        5'h15, 5'h15, 5'h15, 5'h1D, 5'h10, 5'h1F, 5'h1A, 5'h13, 5'h1C, 5'h10,
        5'h00,
        5'h18, 5'h11,
        5'h00
    };

    task automatic chk(input bit ok, input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got line/drv=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_out(input string tag, input logic eb, input logic ed);
        chk({line_bit, drv_en} === {eb, ed}, tag, {line_bit, drv_en}, {eb, ed});
    endtask

    // R2 R3 R4 R5: one nibble, txd scrambled between strobes
    task automatic send_nib(input logic [3:0] d);
        nib_en = 1'b1; tx_en = 1'b1; txd = d;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (k == 0) begin nib_en = 1'b0; txd = ~d; end
            cmp_out("R3/R4/R5 data cell", (k % 2) ? d[k/2] : ~d[k/2], 1'b1);
        end
    endtask

    // R6 R7 R8: idle marker, quiet gap, pulse, quiet
    task automatic end_frame();
        nib_en = 1'b1; tx_en = 1'b0;
        for (int k = 0; k < TAIL + GAP + PULSE + 3; k++) begin
            @(negedge clk);
            if (k == 0) nib_en = 1'b0;
            if (k < TAIL)                     cmp_out("R6 idle marker", 1'b1, 1'b1);
            else if (k < TAIL + GAP)          cmp_out("R6/R8 quiet gap", 1'b0, 1'b0);
            else if (k < TAIL + GAP + PULSE)  cmp_out("R7 link pulse", 1'b1, 1'b1);
            else                              cmp_out("R7 after pulse", 1'b0, 1'b0);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got line/drv=%b expected end of run", {line_bit, drv_en});
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp_out("R1 in reset", 1'b0, 1'b0);
        rst = 1'b0;
        // R1 R7: first pulse after GAP cycles from reset release
        for (int n = 1; n <= GAP + PULSE + 2; n++) begin
            @(negedge clk);
            if (n >= GAP && n < GAP + PULSE) cmp_out("R7 first pulse", 1'b1, 1'b1);
            else                             cmp_out("R1/R7 quiet after reset", 1'b0, 1'b0);
        end

        // table walk: long frame (R8: exceeds GAP), end, short frame, end
        for (int i = 0; i < 14; i++) begin
            if (VEC[i][4]) send_nib(VEC[i][3:0]);
            else           end_frame();
        end

        // R9: stray end strobe outside a frame
        nib_en = 1'b1; tx_en = 1'b0; txd = 4'hF;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (k == 0) nib_en = 1'b0;
            cmp_out("R9 stray strobe ignored", 1'b0, 1'b0);
        end

        // frame starting during an idle marker preempts it
        send_nib(4'h6);
        nib_en = 1'b1; tx_en = 1'b0;
        @(negedge clk); nib_en = 1'b0;
        cmp_out("R6 marker start", 1'b1, 1'b1);
        @(negedge clk);
        send_nib(4'h9);

        // R1: reset in mid-frame
        nib_en = 1'b1; tx_en = 1'b1; txd = 4'h3;
        @(negedge clk); nib_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        cmp_out("R1 reset mid-frame", 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        cmp_out("R1 after reset release", 1'b0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule